// File: doc/BRIEF.md
# Up/Down Hardware Counter Field

This block is a single register field whose value is moved by hardware. Two request inputs, one for counting up and one for counting down, may be raised alone or together in any cycle. Each direction has its own step: either a constant fixed at elaboration or a value taken from a step input whose width is a parameter. When both requests are active, the two steps are combined into one net change and applied in a single cycle.

Each direction is configured on its own to either clamp at its end of the range or wrap modulo 2^WIDTH. A one-cycle event pulse reports every count that would pass the top or the bottom of the range. Two level flags compare the count with an upper and a lower threshold. Software reads the count directly and loads a new value with a write strobe, and a write overrides counting in the same cycle. Address decoding belongs to the surrounding register file.

Top module: `hw_count_field`

## Requirements
- R1: With rst_n low at a rising edge, count loads RESET_VAL (default 0x10) and both event outputs are 0 after that edge.
- R2: With only up_req high, count rises by the unsigned value on up_step (dynamic step, UP_W bits by default) at the next edge.
- R3: With only dn_req high, count falls by the static step DN_STEP (default 2); the dn_step input has no effect while the down step is static.
- R4: With up_req and dn_req both high, count changes by the up step minus the down step in one cycle.
- R5: When an update would pass 2^WIDTH-1, ovf_evt is 1 for that one cycle; with UP_SAT=1 (default) count is held at 2^WIDTH-1, even when the step is larger than the remaining headroom.
- R6: When an update would go below 0, unf_evt is 1 for that one cycle; with DN_SAT=0 (default) count wraps modulo 2^WIDTH.
- R7: A write (wr_en high) loads wr_data at the next edge, overrides any counting requests, and raises no event.
- R8: up_thr_hit is 1 exactly while count is greater than or equal to UP_THR (default 0xF0).
- R9: dn_thr_hit is 1 exactly while count is less than or equal to DN_THR (default 0x08).
- R10: With no request and no write, or an up request with a zero step, count holds and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_req | input | 1 | Request to count up this cycle |
| up_step | input | UP_W | Up step, used when the up step is dynamic |
| dn_req | input | 1 | Request to count down this cycle |
| dn_step | input | DN_W | Down step, used when the down step is dynamic |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WIDTH | Value loaded by a software write |
| count | output | WIDTH | Current counter value |
| ovf_evt | output | 1 | One-cycle pulse: an update passed the top of the range |
| unf_evt | output | 1 | One-cycle pulse: an update passed the bottom of the range |
| up_thr_hit | output | 1 | Count is at or above the upper threshold |
| dn_thr_hit | output | 1 | Count is at or below the lower threshold |

## Verification
The count, ovf_evt and unf_evt come from registers, so a stimulus set up before edge n appears on them just after edge n. The two threshold flags decode the registered count without any further register, so they follow the count with no extra delay. The driver applies each stimulus at a falling edge and queues the values due after the next rising edge. The monitor takes one entry from the queue 1 ns after each rising edge and compares all five outputs, so every comparison is made exactly one edge after its stimulus.

// File: rtl/cnt_field_pkg.sv
// Package: shared types for the counter field.
// Assumes: nothing beyond IEEE 1800-2017.
package cnt_field_pkg;

    // Outcome of one counting step before any clamping or wrap.
    typedef enum logic [1:0] {
        RANGE_IN   = 2'd0,
        RANGE_OVER = 2'd1,
        RANGE_UNDER = 2'd2
    } range_e;

endpackage

// File: rtl/cnt_step_sel.sv
// Module: cnt_step_sel
// Chooses the step for one counting direction: a constant from a parameter
// or a zero-extended dynamic input, gated by the request.
// Assumes: IN_W <= OUT_W and STATIC_STEP fits in OUT_W bits.
module cnt_step_sel #(
    parameter int OUT_W       = 8,
    parameter int IN_W        = 4,
    parameter bit DYNAMIC     = 1'b1,
    parameter int STATIC_STEP = 1
) (
    input  logic             req,
    input  logic [IN_W-1:0]  step_in,
    output logic [OUT_W-1:0] amount
);

    localparam int PAD_W = OUT_W - IN_W;

    logic [OUT_W-1:0] raw_step;

    // Pick the step source given by the parameter.
    generate
        if (DYNAMIC) begin : g_dyn
            if (PAD_W > 0) begin : g_pad
                assign raw_step = {{PAD_W{1'b0}}, step_in};
            end else begin : g_nopad
                assign raw_step = step_in;
            end
        end else begin : g_static
            logic unused_step_in;
            assign unused_step_in = ^step_in;
            assign raw_step = OUT_W'(STATIC_STEP);
        end
    endgenerate

    // Gate the step with the request.
    always_comb begin
        amount = req ? raw_step : '0;
    end

endmodule

// File: rtl/cnt_next_calc.sv
// Module: cnt_next_calc
// Combines the current count with the up and down amounts, classifies the
// result against the range and applies clamp or wrap per direction.
// Assumes: amounts are at most 2^WIDTH-1 each, so WIDTH+2 bits hold the sum.
module cnt_next_calc
    import cnt_field_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit UP_SAT = 1'b1,
    parameter bit DN_SAT = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] up_amt,
    input  logic [WIDTH-1:0] dn_amt,
    output logic [WIDTH-1:0] nxt,
    output range_e           range_st
);

    localparam int EXT_W = WIDTH + 2;
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [EXT_W-1:0] total;

    // Net change in two's complement with two guard bits.
    always_comb begin
        total = {2'b00, cur} + {2'b00, up_amt} - {2'b00, dn_amt};
    end

    // Classify the total: sign bit means below zero, carry bit means above top.
    always_comb begin
        if (total[EXT_W-1]) begin
            range_st = RANGE_UNDER;
        end else if (total[WIDTH]) begin
            range_st = RANGE_OVER;
        end else begin
            range_st = RANGE_IN;
        end
    end

    // Clamp or wrap according to the direction settings.
    always_comb begin
        unique case (range_st)
            RANGE_OVER:  nxt = UP_SAT ? TOP : total[WIDTH-1:0];
            RANGE_UNDER: nxt = DN_SAT ? '0  : total[WIDTH-1:0];
            default:     nxt = total[WIDTH-1:0];
        endcase
    end

endmodule

// File: rtl/cnt_thresh_cmp.sv
// Module: cnt_thresh_cmp
// Level flags comparing the registered count with an upper and a lower
// threshold.
// Assumes: thresholds fit in WIDTH bits.
module cnt_thresh_cmp #(
    parameter int WIDTH = 8,
    parameter int UP_THR = 240,
    parameter int DN_THR = 8
) (
    input  logic [WIDTH-1:0] cnt,
    output logic             up_hit,
    output logic             dn_hit
);

    localparam logic [WIDTH-1:0] UP_LIM = WIDTH'(UP_THR);
    localparam logic [WIDTH-1:0] DN_LIM = WIDTH'(DN_THR);

    // Compare against both thresholds, inclusive.
    always_comb begin
        up_hit = (cnt >= UP_LIM);
        dn_hit = (cnt <= DN_LIM);
    end

endmodule

// File: rtl/hw_count_field.sv
// Module: hw_count_field
// Register field counted by hardware up and down, with per-direction steps
// (static or dynamic), per-direction clamp or wrap, range event pulses,
// threshold flags and a software load that overrides counting.
// Assumes: single clock; synchronous active-low reset; UP_W, DN_W <= WIDTH.
module hw_count_field
    import cnt_field_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int RESET_VAL = 16,
    parameter bit UP_DYN    = 1'b1,
    parameter int UP_W      = 4,
    parameter int UP_STEP   = 1,
    parameter bit DN_DYN    = 1'b0,
    parameter int DN_W      = 4,
    parameter int DN_STEP   = 2,
    parameter bit UP_SAT    = 1'b1,
    parameter bit DN_SAT    = 1'b0,
    parameter int UP_THR    = 240,
    parameter int DN_THR    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_req,
    input  logic [UP_W-1:0]  up_step,
    input  logic             dn_req,
    input  logic [DN_W-1:0]  dn_step,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count,
    output logic             ovf_evt,
    output logic             unf_evt,
    output logic             up_thr_hit,
    output logic             dn_thr_hit
);

    localparam logic [WIDTH-1:0] RST_V = WIDTH'(RESET_VAL);
    localparam logic [WIDTH-1:0] TOP   = {WIDTH{1'b1}};

    logic [WIDTH-1:0] up_amt;
    logic [WIDTH-1:0] dn_amt;
    logic [WIDTH-1:0] cnt_nxt;
    range_e           rng;

    cnt_step_sel #(
        .OUT_W(WIDTH), .IN_W(UP_W), .DYNAMIC(UP_DYN), .STATIC_STEP(UP_STEP)
    ) u_up_step (
        .req(up_req), .step_in(up_step), .amount(up_amt)
    );

    cnt_step_sel #(
        .OUT_W(WIDTH), .IN_W(DN_W), .DYNAMIC(DN_DYN), .STATIC_STEP(DN_STEP)
    ) u_dn_step (
        .req(dn_req), .step_in(dn_step), .amount(dn_amt)
    );

    cnt_next_calc #(
        .WIDTH(WIDTH), .UP_SAT(UP_SAT), .DN_SAT(DN_SAT)
    ) u_calc (
        .cur(count), .up_amt(up_amt), .dn_amt(dn_amt),
        .nxt(cnt_nxt), .range_st(rng)
    );

    cnt_thresh_cmp #(
        .WIDTH(WIDTH), .UP_THR(UP_THR), .DN_THR(DN_THR)
    ) u_thr (
        .cnt(count), .up_hit(up_thr_hit), .dn_hit(dn_thr_hit)
    );

    // Count register and event pulses; write beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= RST_V;
            ovf_evt <= 1'b0;
            unf_evt <= 1'b0;
        end else if (wr_en) begin
            count   <= wr_data;
            ovf_evt <= 1'b0;
            unf_evt <= 1'b0;
        end else begin
            count   <= cnt_nxt;
            ovf_evt <= (rng == RANGE_OVER);
            unf_evt <= (rng == RANGE_UNDER);
        end
    end

    // R1: reset loads the reset value and clears events.
    a_r1_reset_load: assert property (@(posedge clk)
        !rst_n |=> (count == RST_V) && !ovf_evt && !unf_evt);

    // R7: a write lands at the next edge with no event.
    a_r7_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)) && !ovf_evt && !unf_evt);

    // R10: nothing requested means nothing moves.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_req && !dn_req && !wr_en) |=> $stable(count) && !ovf_evt && !unf_evt);

    // R5 and R6: the two events never coincide.
    a_r6_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_evt && unf_evt));

    // R5/R6: clamped directions sit at their limit when they report an event.
    generate
        if (UP_SAT) begin : g_up_sat_chk
            a_r5_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
                ovf_evt |-> (count == TOP));
        end
        if (DN_SAT) begin : g_dn_sat_chk
            a_r6_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
                unf_evt |-> (count == '0));
        end
    endgenerate

endmodule

// File: tb/hw_count_field_bench.sv
`timescale 1ns/100ps
// Bench: scoreboard for hw_count_field at default parameters.
module hw_count_field_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_req = 1'b0;
    logic [3:0]   up_step = '0;
    logic         dn_req = 1'b0;
    logic [3:0]   dn_step = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic         ovf_evt, unf_evt, up_thr_hit, dn_thr_hit;

    typedef struct {
        logic [W-1:0] cnt;
        logic ov, un, uh, dh;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int model_cnt = 16;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hw_count_field u_hw_count_field (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_step(up_step),
        .dn_req(dn_req), .dn_step(dn_step), .wr_en(wr_en), .wr_data(wr_data),
        .count(count), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
        .up_thr_hit(up_thr_hit), .dn_thr_hit(dn_thr_hit)
    );

    // Driver: apply one cycle of stimulus and queue the result due after the edge.
    task automatic apply(input bit rs, input bit ur, input int us,
                         input bit dr, input int ds, input bit we,
                         input int wd, input string tag);
        exp_t e;
        int sum;
        @(negedge clk);
        rst_n = ~rs; up_req = ur; up_step = 4'(us);
        dn_req = dr; dn_step = 4'(ds); wr_en = we; wr_data = W'(wd);
        e.ov = 1'b0; e.un = 1'b0;
        if (rs) begin
            model_cnt = 16;
        end else if (we) begin
            model_cnt = wd & 255;
        end else begin
            sum = model_cnt + (ur ? us : 0) - (dr ? 2 : 0);
            if (sum > 255) begin
                e.ov = 1'b1; model_cnt = 255;
            end else if (sum < 0) begin
                e.un = 1'b1; model_cnt = sum + 256;
            end else begin
                model_cnt = sum;
            end
        end
        e.cnt = W'(model_cnt);
        e.uh = (model_cnt >= 240);
        e.dh = (model_cnt <= 8);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare one queued entry 1 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (count !== e.cnt || ovf_evt !== e.ov || unf_evt !== e.un ||
                    up_thr_hit !== e.uh || dn_thr_hit !== e.dh) begin
                    errors++;
                    $display("FAIL %s: got cnt=%h ov=%b un=%b uh=%b dh=%b exp cnt=%h ov=%b un=%b uh=%b dh=%b",
                             e.tag, count, ovf_evt, unf_evt, up_thr_hit, dn_thr_hit,
                             e.cnt, e.ov, e.un, e.uh, e.dh);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        apply(1, 0, 0, 0, 0, 0, 0,    "R1 reset value");
        apply(0, 1, 3, 0, 0, 0, 0,    "R2 up by dynamic 3");
        apply(0, 0, 0, 1, 7, 0, 0,    "R3 down by static 2, dn_step ignored");
        apply(0, 1, 5, 1, 9, 0, 0,    "R4 up 5 down 2 net");
        apply(0, 1, 4, 1, 0, 1, 7,    "R7 write beats requests");
        apply(0, 0, 0, 0, 0, 1, 254,  "R7 write 0xFE");
        apply(0, 1, 4, 0, 0, 0, 0,    "R5 clamp at top");
        apply(0, 1, 15, 0, 0, 0, 0,   "R5 step over headroom at top");
        apply(0, 0, 0, 0, 0, 0, 0,    "R10 idle after overflow");
        apply(0, 0, 0, 0, 0, 1, 1,    "R7 write 0x01");
        apply(0, 0, 0, 1, 0, 0, 0,    "R6 wrap below zero");
        apply(0, 0, 0, 0, 0, 0, 0,    "R6 pulse ends");
        apply(0, 1, 0, 0, 0, 0, 0,    "R10 zero step holds");
        apply(0, 0, 0, 0, 0, 1, 240,  "R8 flag at threshold");
        apply(0, 0, 0, 0, 0, 1, 239,  "R8 flag below threshold");
        apply(0, 0, 0, 0, 0, 1, 8,    "R9 flag at threshold");
        apply(0, 0, 0, 0, 0, 1, 9,    "R9 flag above threshold");
        apply(0, 1, 2, 1, 0, 0, 0,    "R4 equal steps cancel");
        apply(1, 1, 9, 0, 0, 1, 99,   "R1 reset beats write");
        @(negedge clk);
        rst_n = 1'b1; up_req = 1'b0; dn_req = 1'b0; wr_en = 1'b0;
        wait (exp_q.size() == 0);
        @(posedge clk);
        #2;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5 * 5000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule